// File: doc/BRIEF.md
# Transmit Word Polarity Inverter and Bit Slipper

This block sits just ahead of a serializer on the transmit side. Each parallel clock it takes one 10-bit word. It can move the word boundary later in the serial stream by zero to nine bit positions, and it can invert every bit of the word it outputs. The serializer is assumed to send bit 0 of each word first. A slip of `s` therefore delays the whole stream by `s` bit times. The top `s` bits of each word move into the low positions of the following output word, so no bit is lost.

The polarity control and the slip amount are asynchronous to the parallel clock. The driver holds each setting for at least two parallel clock cycles. Each control passes through its own two-flop synchronizer before it is used, so a new setting takes effect a fixed number of cycles after it changes. The output word is registered, which gives one cycle of latency from input word to output word.

Top module: `tx_slip_invert`

## Requirements
- R1: While `rstN` is low, `wordOut` is all zeros. After reset the block behaves as if polarity is off and slip is 0, until the synchronized controls say otherwise.
- R2: With slip 0 and polarity off, the word sampled at a clock edge appears unchanged on `wordOut` right after that edge.
- R3: With polarity on and slip 0, `wordOut` is the bitwise inverse of all 10 bits of the word sampled at the preceding edge.
- R4: With a slip `s` from 1 to 9 and polarity off, bit `i` of the output produced at an edge equals bit `i-s` of the word sampled at that edge when `i >= s`. Otherwise it equals bit `10-s+i` of the word sampled one edge earlier.
- R5: With slip `s` > 0, the top `s` bits of the previous input word appear in output bits `s-1..0`, so the concatenated output stream carries every input bit.
- R6: Slip values 10 to 15 have the same effect as 0.
- R7: A control value applied before clock edge `n` and held for at least two cycles first affects the output produced at edge `n+2`. The output produced at edge `n+1` still uses the old setting.
- R8: When polarity and slip are both active, inversion is applied to the already slipped word: `wordOut` equals the bitwise inverse of the R4 result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordIn | input | 10 | Parallel word from the transmit datapath |
| invertAsync | input | 1 | Polarity inversion request, asynchronous |
| slipAsync | input | 4 | Bit slip amount, asynchronous, 0..9 valid |
| wordOut | output | 10 | Adjusted word to the serializer |

## Verification
A bad previous-word register shows up as wrong low bits of the output. This happens only when the slip is nonzero, on the first word after the fault. A synchronizer that is one stage too short or too long moves the first affected output by one cycle, so the bench checks the output words at edges `n+1` and `n+2` around each control change. A bad clamp of out-of-range slips, or inversion applied before the slip, corrupts the very next output word for those settings.

// File: rtl/tx_slip_pkg.sv
package tx_slip_pkg;
  localparam int WORD_W = 10;
  localparam int SLIP_W = 4;

  typedef struct packed {
    logic              invert;
    logic [SLIP_W-1:0] slip;
  } ctrlStrobe_t;
endpackage

// File: rtl/tx_slip_ctrl.sv
module tx_slip_ctrl
  import tx_slip_pkg::*;
#(
  parameter int WIDTH  = WORD_W,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invertAsync,
  input  logic [SLIP_W-1:0] slipAsync,
  output ctrlStrobe_t       ctrl
);
  localparam int CW = 1 + SLIP_W;

  logic [CW-1:0] syncReg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncReg[g] <= '0;
        end else if (g == 0) begin
          syncReg[g] <= {invertAsync, slipAsync};
        end else begin
          syncReg[g] <= syncReg[g-1];
        end
      end
    end
  endgenerate

  logic [SLIP_W-1:0] slipSync;
  assign slipSync = syncReg[STAGES-1][SLIP_W-1:0];

  always_comb begin
    ctrl.invert = syncReg[STAGES-1][CW-1];
    ctrl.slip   = (int'(slipSync) >= WIDTH) ? '0 : slipSync;
  end
endmodule

// File: rtl/tx_slip_dp.sv
module tx_slip_dp
  import tx_slip_pkg::*;
#(
  parameter int WIDTH = WORD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic [WIDTH-1:0] wordIn,
  output logic [WIDTH-1:0] wordOut
);
  localparam int JOIN_W = 2 * WIDTH;

  logic [WIDTH-1:0]  prevWord;
  logic [JOIN_W-1:0] joined;
  logic [WIDTH-1:0]  slipped;
  logic [WIDTH-1:0]  polarized;

  always_comb begin
    joined    = {wordIn, prevWord} << ctrl.slip;
    slipped   = joined[JOIN_W-1:WIDTH];
    polarized = ctrl.invert ? ~slipped : slipped;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
      wordOut  <= '0;
    end else begin
      prevWord <= wordIn;
      wordOut  <= polarized;
    end
  end
endmodule

// File: rtl/tx_slip_invert.sv
module tx_slip_invert
  import tx_slip_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              invertAsync,
  input  logic [SLIP_W-1:0] slipAsync,
  output logic [WORD_W-1:0] wordOut
);
  ctrlStrobe_t ctrl;

  tx_slip_ctrl #(.WIDTH(WORD_W), .STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .invertAsync(invertAsync),
    .slipAsync(slipAsync), .ctrl(ctrl)
  );

  tx_slip_dp #(.WIDTH(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wordIn(wordIn), .wordOut(wordOut)
  );
endmodule

// File: rtl/tx_slip_chk.sv
module tx_slip_chk
  import tx_slip_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] wordIn,
  input logic              invertAsync,
  input logic [SLIP_W-1:0] slipAsync,
  input logic [WORD_W-1:0] wordOut
);
  logic [2:0] since;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) since <= '0;
    else if (since != 3'd7) since <= since + 3'd1;
  end
  logic ready;
  assign ready = (since >= 3'd4);

  function automatic logic [WORD_W-1:0] refSlip(input logic [WORD_W-1:0] cur,
                                                 input logic [WORD_W-1:0] prev,
                                                 input int s);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++)
      r[i] = (i >= s) ? cur[i-s] : prev[WORD_W-s+i];
    return r;
  endfunction

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rstN |-> wordOut == '0);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(invertAsync, 3) && $past(slipAsync, 3) == 4'd0)
      |-> wordOut == $past(wordIn));

  // R3
  invert_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(invertAsync, 3) && $past(slipAsync, 3) == 4'd0)
      |-> wordOut == ~$past(wordIn));

  // R6
  slip_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(invertAsync, 3) && $past(slipAsync, 3) >= 4'd10)
      |-> wordOut == $past(wordIn));

  // R4
  slip_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !$past(invertAsync, 3) && $past(slipAsync, 3) != 4'd0
           && $past(slipAsync, 3) < 4'd10)
      |-> wordOut == refSlip($past(wordIn), $past(wordIn, 2), int'($past(slipAsync, 3))));

  // R8
  slip_then_invert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(invertAsync, 3) && $past(slipAsync, 3) != 4'd0
           && $past(slipAsync, 3) < 4'd10)
      |-> wordOut == ~refSlip($past(wordIn), $past(wordIn, 2), int'($past(slipAsync, 3))));
endmodule

bind tx_slip_invert tx_slip_chk uChk (
  .clk(clk), .rstN(rstN), .wordIn(wordIn), .invertAsync(invertAsync),
  .slipAsync(slipAsync), .wordOut(wordOut)
);

// File: tb/sim_tx_slip_invert.sv
`timescale 1ns/1ps
module sim_tx_slip_invert;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] wordIn = '0;
  logic       invertAsync = 1'b0;
  logic [3:0] slipAsync = '0;
  logic [9:0] wordOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx_slip_invert u0 (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .invertAsync(invertAsync),
    .slipAsync(slipAsync), .wordOut(wordOut)
  );

  logic [9:0] prevW;
  logic       invH1, invH2;
  logic [3:0] slipH1, slipH2;

  function automatic logic [9:0] expWord(input logic [9:0] cur, input logic [9:0] prev,
                                         input logic inv, input logic [3:0] slip);
    int s;
    logic [9:0] r;
    s = (slip > 4'd9) ? 0 : int'(slip);
    for (int i = 0; i < 10; i++)
      r[i] = (i >= s) ? cur[i-s] : prev[10-s+i];
    return inv ? ~r : r;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] w, input logic inv, input logic [3:0] slip);
    logic [9:0] e;
    string req;
    int s;
    @(negedge clk);
    wordIn = w;
    invertAsync = inv;
    slipAsync = slip;
    @(posedge clk);
    #2;
    e = expWord(w, prevW, invH2, slipH2);
    s = (slipH2 > 4'd9) ? 0 : int'(slipH2);
    if (invH2 && s != 0) req = "R8";
    else if (invH2) req = "R3";
    else if (slipH2 > 4'd9) req = "R6";
    else if (s != 0) req = "R4";
    else req = "R2";
    check(req, wordOut, e);
    if (s != 0) begin
      logic [9:0] low;
      low = invH2 ? ~wordOut : wordOut;
      check("R5", 10'(low & ((10'd1 << s) - 10'd1)), 10'(prevW >> (10 - s)));
    end
    invH2 = invH1;   slipH2 = slipH1;
    invH1 = inv;     slipH1 = slip;
    prevW = w;
  endtask

  initial begin
    prevW = '0; invH1 = 0; invH2 = 0; slipH1 = '0; slipH2 = '0;
    void'($urandom(32'd1234));
    #12;
    check("R1", wordOut, 10'd0);
    wordIn = 10'h3FF; invertAsync = 1'b1; slipAsync = 4'd5;
    #6;
    check("R1", wordOut, 10'd0);
    @(negedge clk);
    wordIn = '0; invertAsync = 1'b0; slipAsync = '0;
    rstN = 1'b1;
    // R2 directed pass-through
    step(10'h2A5, 0, 0);
    step(10'h15A, 0, 0);
    step(10'h3C3, 0, 0);
    // R7 directed: invert turns on before an edge; next output still plain, the one after inverted
    step(10'h0F0, 1, 0);
    check("R7", wordOut, 10'h0F0);
    step(10'h123, 1, 0);
    check("R7", wordOut, 10'h123);
    step(10'h321, 1, 0);
    check("R7", wordOut, ~10'h321);
    step(10'h321, 0, 0);
    step(10'h000, 0, 0);
    step(10'h000, 0, 0);
    // R4/R5 directed: slip 9 and 1, walking ones
    for (int k = 0; k < 4; k++) step(10'h201, 0, 9);
    for (int k = 0; k < 4; k++) step(10'h001 << k, 0, 1);
    // R6: out-of-range slips behave as 0
    for (int k = 10; k < 16; k++) begin
      step(10'(k * 37), 0, 4'(k));
      step(10'(k * 91), 0, 4'(k));
    end
    // random mix, controls held at least two cycles
    begin
      logic inv;
      logic [3:0] sl;
      inv = 0; sl = 0;
      for (int n = 0; n < 600; n++) begin
        if (n % 2 == 0 && ($urandom % 3) == 0) begin
          inv = 1'($urandom);
          sl = 4'($urandom % 16);
        end
        step(10'($urandom), inv, sl);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule